// File: doc/BRIEF.md
# Two-Wire Register GPIO Expander

This block turns a two-wire serial slave interface into eight general-purpose pins. A host addresses the block, sends a command byte that picks one of four 8-bit registers, and then writes that register or reads it back. The four registers are a pin-level view, an output value, a per-bit input inversion mask and a per-bit direction mask. Each pin is steered independently between input and output. Pin 0 can only sink current.

Both serial lines pass through a two-flop synchronizer and a persistence filter before the protocol engine sees them. The engine samples on the filtered clock's rising edge and changes its data drive on the filtered falling edge. It pulls the data line low through `sda_pull` and never drives it high. The active-low reset clears the registers and returns the serial engine to idle.

Top module: `gpio_expander_2w`

## Requirements
- R1: After reset, direction is 0xFF, output value is 0x00 and inversion mask is 0x00. All `pin_oe` bits are 0 and `sda_pull` is 0.
- R2: The block acknowledges only the slave address `{4'b0011, addr_sel}`. Bit 0 of the address byte is the read flag (1 = read). For any other address it never pulls SDA, and its registers are unchanged.
- R3: The first byte after a write address is a command byte. Its bits [1:0] select the register: 0 = pin levels, 1 = output value, 2 = inversion mask, 3 = direction. Every following byte in the same transaction writes that register, and every byte is acknowledged.
- R4: Bytes written while the command selects register 0 are acknowledged and have no effect on any register.
- R5: A read returns the register chosen by the last command byte. Register 0 reads as `pin_in ^ inversion mask`.
- R6: For pins 1 to 7, direction bit 1 means input (`pin_oe` 0), and bit 0 means output, with `pin_out` equal to the output value bit.
- R7: Pin 0 is open drain. `pin_out[0]` is always 0. `pin_oe[0]` is 1 only when direction bit 0 is 0 and output bit 0 is 0.
- R8: During a read, a host ACK makes the block send the same register again. A host NACK makes the block release SDA and go idle.
- R9: A STOP releases SDA. A repeated START restarts address decoding, so a write of the command can be followed directly by a read.
- R10: A pulse on SCL or SDA shorter than `FILT_LEN` clock cycles is ignored by the protocol engine.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 3 | Low three bits of the slave address |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_pull | output | 1 | 1 pulls the data line low |
| pin_in | input | 8 | Pin levels as seen at the pads |
| pin_out | output | 8 | Pin drive values |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
Random write/read pairs use random register selectors, data and pin levels. They separate the four register paths from one another and show that the inversion mask folds into pin reads. After each write the pin outputs are compared with a bench model of direction and pin 0's open-drain rule. Directed transactions add the following cases:
- a foreign address, which must not disturb state;
- a write to the pin-level register, which must be ignored;
- multi-byte writes, and reads ended by host ACK and NACK, which tell a sticky register pointer from a drifting one;
- a short SCL glitch inside a data byte, which exposes a missing or weak filter as a corrupted value.

// File: rtl/gpio_expander_2w.sv
module gpio_expander_2w #(
  parameter int         FILT_LEN = 4,
  parameter logic [3:0] ADDR_HI  = 4'b0011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr_sel,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull,
  input  logic [7:0] pin_in,
  output logic [7:0] pin_out,
  output logic [7:0] pin_oe
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] FMAX = CW'(FILT_LEN - 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_MACK} st_t;

  logic [1:0]    s1, s2, filt, filt_d;
  logic [CW-1:0] fcnt [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 2'b11; s2 <= 2'b11; filt <= 2'b11; filt_d <= 2'b11;
      for (int k = 0; k < 2; k++) fcnt[k] <= '0;
    end else begin
      s1 <= {scl_in, sda_in};
      s2 <= s1;
      filt_d <= filt;
      for (int k = 0; k < 2; k++) begin
        if (s2[k] == filt[k]) fcnt[k] <= '0;
        else if (fcnt[k] == FMAX) begin
          filt[k] <= s2[k];
          fcnt[k] <= '0;
        end else fcnt[k] <= fcnt[k] + 1'b1;
      end
    end
  end

  wire scl_f    = filt[1];
  wire sda_f    = filt[0];
  wire scl_rise = scl_f & ~filt_d[1];
  wire scl_fall = ~scl_f & filt_d[1];
  wire start_ev = scl_f & filt_d[1] & filt_d[0] & ~sda_f;
  wire stop_ev  = scl_f & filt_d[1] & ~filt_d[0] & sda_f;

  st_t        state;
  logic [7:0] sh, out_q, pol_q, cfg_q;
  logic [3:0] cnt;
  logic [1:0] ptr;
  logic       rw, cmd_next, pull;
  logic [7:0] rd_val;

  always_comb begin
    case (ptr)
      2'd0:    rd_val = pin_in ^ pol_q;
      2'd1:    rd_val = out_q;
      2'd2:    rd_val = pol_q;
      default: rd_val = cfg_q;
    endcase
  end

  wire addr_hit = (sh[7:1] == {ADDR_HI, addr_sel});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; sh <= '0; cnt <= '0; ptr <= '0;
      rw <= 1'b0; cmd_next <= 1'b0; pull <= 1'b0;
      out_q <= 8'h00; pol_q <= 8'h00; cfg_q <= 8'hFF;
    end else if (start_ev) begin
      state <= S_ADDR; cnt <= '0; pull <= 1'b0;
    end else if (stop_ev) begin
      state <= S_IDLE; pull <= 1'b0;
    end else begin
      case (state)
        S_ADDR, S_WR: begin
          if (scl_rise) begin
            sh  <= {sh[6:0], sda_f};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            if (state == S_ADDR) begin
              if (addr_hit) begin
                state <= S_AACK; pull <= 1'b1; rw <= sh[0];
              end else state <= S_IDLE;
            end else begin
              state <= S_WACK; pull <= 1'b1;
              if (cmd_next) begin
                ptr <= sh[1:0]; cmd_next <= 1'b0;
              end else begin
                case (ptr)
                  2'd1:    out_q <= sh;
                  2'd2:    pol_q <= sh;
                  2'd3:    cfg_q <= sh;
                  default: ;
                endcase
              end
            end
          end
        end
        S_AACK: if (scl_fall) begin
          cnt <= '0;
          if (rw) begin
            sh <= rd_val; pull <= ~rd_val[7]; state <= S_RD;
          end else begin
            pull <= 1'b0; cmd_next <= 1'b1; state <= S_WR;
          end
        end
        S_WACK: if (scl_fall) begin
          pull <= 1'b0; cnt <= '0; state <= S_WR;
        end
        S_RD: if (scl_fall) begin
          if (cnt == 4'd7) begin
            pull <= 1'b0; state <= S_MACK;
          end else begin
            sh <= {sh[6:0], 1'b0}; pull <= ~sh[6]; cnt <= cnt + 4'd1;
          end
        end
        S_MACK: begin
          if (scl_rise && sda_f) state <= S_IDLE;
          else if (scl_fall) begin
            sh <= rd_val; pull <= ~rd_val[7]; cnt <= '0; state <= S_RD;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pull = pull;
  assign pin_out  = {out_q[7:1], 1'b0};
  assign pin_oe   = {~cfg_q[7:1], ~cfg_q[0] & ~out_q[0]};

  // R2
  foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ADDR && scl_fall && cnt == 4'd8 && !addr_hit && !start_ev && !stop_ev)
      |=> (state == S_IDLE && !sda_pull));
  // R3
  reg_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(state == S_WR && scl_fall && cnt == 4'd8 && !cmd_next)
      |=> $stable({out_q, pol_q, cfg_q}));
  // R6
  dir_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe[7:1] & cfg_q[7:1]) == 7'd0);
  // R7
  od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_q[0] |-> !pin_oe[0]);
  // R8
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_MACK && scl_rise && sda_f && !stop_ev && !start_ev)
      |=> (state == S_IDLE && !sda_pull));
  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_pull);
  // R10
  filter_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt[1]) |-> $past(s2[1]) == filt[1]);
endmodule

// File: tb/gpio_expander_2w_tb.sv
module gpio_expander_2w_tb_top;
  localparam int Q = 12;
  localparam logic [2:0] ASEL = 3'b101;

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1, glitch = 0, glitch_en = 0;
  logic [7:0] pin_in = 8'h00;
  logic sda_pull;
  logic [7:0] pin_out, pin_oe;
  wire scl_line = scl_m & ~glitch;
  wire sda_line = sda_m & ~sda_pull;

  always #4 clk = ~clk;

  gpio_expander_2w dut_i (
    .clk(clk), .rst_n(rst_n), .addr_sel(ASEL), .scl_in(scl_line), .sda_in(sda_line),
    .sda_pull(sda_pull), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  int checks = 0, fails = 0;
  logic [7:0] m_out = 8'h00, m_pol = 8'h00, m_cfg = 8'hFF;

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_oe(input logic [7:0] c, input logic [7:0] o);
    return {~c[7:1], ~c[0] & ~o[0]};
  endfunction
  function automatic logic [7:0] exp_rd(input logic [1:0] s, input logic [7:0] p);
    case (s)
      2'd0: return p ^ m_pol;
      2'd1: return m_out;
      2'd2: return m_pol;
      default: return m_cfg;
    endcase
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask
  task automatic i2c_stop();
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
  endtask
  task automatic bit_io(input logic b, input bit gl, output logic r);
    sda_m = b; tick(Q); scl_m = 1; tick(Q);
    if (gl) begin glitch = 1; tick(2); glitch = 0; tick(2); end
    r = sda_line; tick(Q); scl_m = 0; tick(Q);
  endtask
  task automatic wbyte(input logic [7:0] d, output bit ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(d[i], glitch_en, r);
    bit_io(1'b1, 1'b0, r);
    ack = !r;
  endtask
  task automatic rbyte(input bit mack, output logic [7:0] d);
    logic r;
    d = '0;
    for (int i = 0; i < 8; i++) begin bit_io(1'b1, 1'b0, r); d = {d[6:0], r}; end
    bit_io(!mack, 1'b0, r);
  endtask

  task automatic write_reg(input logic [1:0] s, input logic [7:0] d, output bit ok);
    bit a0, a1, a2;
    i2c_start(); wbyte({4'b0011, ASEL, 1'b0}, a0); wbyte({6'd0, s}, a1); wbyte(d, a2); i2c_stop();
    ok = a0 & a1 & a2;
  endtask
  task automatic read_reg(input logic [1:0] s, output logic [7:0] d, output bit ok);
    bit a0, a1, a2;
    i2c_start(); wbyte({4'b0011, ASEL, 1'b0}, a0); wbyte({6'd0, s}, a1);
    i2c_start(); wbyte({4'b0011, ASEL, 1'b1}, a2); rbyte(1'b0, d); i2c_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual %h expected %h", 8'h00, 8'h01);
    report();
  end

  initial begin
    logic [7:0] d, e;
    bit ok;
    void'($urandom(32'h5EED_1234));
    tick(10); rst_n = 1; tick(10);

    chk(pin_oe == 8'h00 && !sda_pull, "R1 reset pins", pin_oe, 8'h00);
    read_reg(2'd3, d, ok); chk(ok && d == 8'hFF, "R1 direction reset", d, 8'hFF);
    read_reg(2'd1, d, ok); chk(ok && d == 8'h00, "R1 output reset", d, 8'h00);
    read_reg(2'd2, d, ok); chk(ok && d == 8'h00, "R1 inversion reset", d, 8'h00);

    for (int n = 0; n < 24; n++) begin
      logic [1:0] s, rs;
      s = 2'($urandom_range(0, 3)); d = 8'($urandom);
      write_reg(s, d, ok);
      chk(ok, "R3 write acks", {7'd0, ok}, 8'h01);
      case (s)
        2'd1: m_out = d;
        2'd2: m_pol = d;
        2'd3: m_cfg = d;
        default: ;
      endcase
      chk(pin_oe == exp_oe(m_cfg, m_out), "R6 R7 pin_oe", pin_oe, exp_oe(m_cfg, m_out));
      chk(pin_out == {m_out[7:1], 1'b0}, "R6 R7 pin_out", pin_out, {m_out[7:1], 1'b0});
      rs = 2'($urandom_range(0, 3)); pin_in = 8'($urandom);
      read_reg(rs, d, ok);
      e = exp_rd(rs, pin_in);
      chk(ok && d == e, "R5 read back", d, e);
    end

    // R4: write to pin-level register is ignored
    e = m_out;
    write_reg(2'd0, ~m_out, ok);
    chk(ok, "R4 ack", {7'd0, ok}, 8'h01);
    read_reg(2'd1, d, ok); chk(d == e, "R4 output untouched", d, e);
    read_reg(2'd0, d, ok); chk(d == (pin_in ^ m_pol), "R4 R5 pin read", d, pin_in ^ m_pol);

    // R2: foreign address
    i2c_start(); wbyte({4'b0011, ~ASEL, 1'b0}, ok);
    chk(!ok, "R2 foreign not acked", {7'd0, ok}, 8'h00);
    wbyte(8'h01, ok); wbyte(8'h3C, ok); i2c_stop();
    read_reg(2'd1, d, ok); chk(d == m_out, "R2 state unchanged", d, m_out);

    // R3: multi-byte write keeps pointer
    begin
      bit a0, a1, a2, a3;
      i2c_start(); wbyte({4'b0011, ASEL, 1'b0}, a0); wbyte(8'h02, a1);
      wbyte(8'h11, a2); wbyte(8'h96, a3); i2c_stop();
      m_pol = 8'h96;
      chk(a0 & a1 & a2 & a3, "R3 multi ack", {4'd0, a0, a1, a2, a3}, 8'h0F);
      read_reg(2'd2, d, ok); chk(d == 8'h96, "R3 last byte wins", d, 8'h96);
    end

    // R8 R9: repeated start, ACKed reads repeat register, NACK releases
    write_reg(2'd3, 8'h5A, ok); m_cfg = 8'h5A;
    begin
      bit a0, a1, a2;
      logic [7:0] d1, d2, d3;
      i2c_start(); wbyte({4'b0011, ASEL, 1'b0}, a0); wbyte(8'h03, a1);
      i2c_start(); wbyte({4'b0011, ASEL, 1'b1}, a2);
      rbyte(1'b1, d1); rbyte(1'b1, d2); rbyte(1'b0, d3);
      chk(a0 & a1 & a2, "R9 repeated start ack", {5'd0, a0, a1, a2}, 8'h07);
      chk(d1 == 8'h5A && d2 == 8'h5A, "R8 repeat on ack", d2, 8'h5A);
      chk(d3 == 8'h5A, "R8 last byte", d3, 8'h5A);
      tick(Q);
      chk(!sda_pull, "R8 released after nack", {7'd0, sda_pull}, 8'h00);
      i2c_stop();
      chk(!sda_pull, "R9 released after stop", {7'd0, sda_pull}, 8'h00);
    end

    // R7: open drain on pin 0
    write_reg(2'd3, 8'hFE, ok); m_cfg = 8'hFE;
    write_reg(2'd1, 8'h01, ok); m_out = 8'h01;
    chk(pin_oe[0] == 1'b0 && pin_out[0] == 1'b0, "R7 high releases", {6'd0, pin_oe[0], pin_out[0]}, 8'h00);
    write_reg(2'd1, 8'h00, ok); m_out = 8'h00;
    chk(pin_oe[0] == 1'b1 && pin_out[0] == 1'b0, "R7 low drives", {6'd0, pin_oe[0], pin_out[0]}, 8'h02);

    // R10: short SCL glitch inside a data byte
    i2c_start(); wbyte({4'b0011, ASEL, 1'b0}, ok); wbyte(8'h01, ok);
    glitch_en = 1; wbyte(8'hA5, ok); glitch_en = 0; i2c_stop();
    m_out = 8'hA5;
    read_reg(2'd1, d, ok); chk(d == 8'hA5, "R10 glitch ignored", d, 8'hA5);
    chk(pin_out == 8'hA4, "R10 R6 pin_out", pin_out, 8'hA4);

    report();
  end
endmodule